// File: doc/BRIEF.md
# Tag-Only Set-Associative Cache Directory

This block models the hit and miss behaviour of a set-associative cache. It holds a tag and a valid flag for every way of every set, but stores no data. A client presents a byte address with a valid/ready handshake. The directory splits the address into three fields: a block offset, which it ignores, a set index and a tag. It compares the tag against every way of the indexed set. One cycle later it reports the outcome: hit or miss, the way that was used, and whether a valid entry had to be evicted.

On a miss the new tag is installed at once, so the next access to the same block hits. An empty way is always used before any valid entry is replaced. Only when the whole set is valid does the directory take the way offered on the `victim_way` input. That input lets any replacement policy (least recently used, first-in first-out, pseudo-random) sit outside the block and watch the response stream. Two free-running counters record the accepted accesses and the misses.

The geometry is fixed at elaboration time. The block size and the number of sets are powers of two, at least 2 each. The total capacity is always a whole number of sets. `rst_n` is expected to be already synchronised to `clk`: it asserts asynchronously and is released on a clock edge.

Top module: `tagdir_top`

## Requirements
- R1: The address splits into three fields. The offset is bits [OFF_W-1:0], where OFF_W = log2(BLOCK_BYTES), and it does not affect the outcome. The set index is the next SET_W = log2(NUM_SETS) bits. The tag is every bit above those two fields. Accesses to different set indices never affect one another.
- R2: An access hits only when some way of the indexed set is valid and holds the access tag. Then `rsp_hit`=1, `rsp_miss`=0 and `rsp_way` is that way.
- R3: On a miss where the set still has an invalid way, the lowest-numbered invalid way is filled. `rsp_way` reports that way, `rsp_evict`=0, and `victim_way` is ignored.
- R4: On a miss where every way is valid, the way given on `victim_way` (which must be below NUM_WAYS) is overwritten, and the response shows `rsp_evict`=1 with `rsp_way` equal to that way.
- R5: A miss installs the access tag in the chosen way and marks it valid. The next access to the same block hits in that way. The tag that was overwritten then misses.
- R6: `access_count` increases by one for every accepted access. `miss_count` increases by one only for accepted accesses that miss. Both wrap modulo 2^CNT_W.
- R7: Reset invalidates every way and clears both counters and `rsp_valid`. While reset is held, `req_ready` is 0.
- R8: `req_ready` is 1 from the first clock edge after reset is released. An access is accepted on an edge where `req_valid` and `req_ready` are both 1. For each accepted access, `rsp_valid` is 1 during exactly the following cycle, with exactly one of `rsp_hit` and `rsp_miss` set. Back-to-back accesses each receive their own response, and each sees the fill made by the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| req_valid | input | 1 | An access is offered |
| req_ready | output | 1 | The directory accepts an access on this edge |
| req_addr | input | ADDR_W | Byte address of the access |
| victim_way | input | WAY_W | Way to replace when the indexed set is full, supplied by the replacement selector |
| rsp_valid | output | 1 | The response for the access accepted on the previous edge is valid |
| rsp_hit | output | 1 | That access hit |
| rsp_miss | output | 1 | That access missed, and its tag has been installed |
| rsp_evict | output | 1 | The miss overwrote a valid entry |
| rsp_way | output | WAY_W | Way that hit or was filled |
| access_count | output | CNT_W | Number of accepted accesses |
| miss_count | output | CNT_W | Number of accepted accesses that missed |

## Verification
The directed tests start with a cold set and fill all eight ways with distinct tags, which shows empty ways being taken in ascending order while the victim input is ignored. The same blocks are then read again at different offsets, which separates a true tag match from any dependence on offset bits. The same tag is then sent to a second set, which shows that sets are kept apart. Finally, misses to the full set with varying victim ways show that replacement is steered from outside, and that exactly the overwritten tag is lost. Back-to-back accesses and a mid-run reset check the one-cycle response timing, the counters and the clearing of every valid flag.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [1:0] {
    OUT_HIT   = 2'd0,
    OUT_FILL  = 2'd1,
    OUT_EVICT = 2'd2
  } tagdir_outcome_e;

endpackage

// File: rtl/tagdir_addr_split.sv
module tagdir_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 5,
  localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SET_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  tag
);

  // The offset bits are dropped: every byte of a block shares one entry.
  assign set_idx = addr[OFF_W +: SET_W];
  assign tag     = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/tagdir_way_search.sv
module tagdir_way_search #(
  parameter int NUM_WAYS = 8,
  parameter int TAG_W    = 21,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              probe,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0]    way_tags,
  input  logic [NUM_WAYS-1:0]               way_valid,
  input  logic [TAG_W-1:0]                  look_tag,
  output logic                              hit,
  output logic [WAY_W-1:0]                  hit_way,
  output logic                              has_free,
  output logic [WAY_W-1:0]                  free_way
);

  logic [NUM_WAYS-1:0] match_vec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match_vec[w] = way_valid[w] && (way_tags[w] == look_tag);
  end

  // Scan from the top way down, so that the lowest index is the one kept.
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match_vec[w])  hit_way  = WAY_W'(w);
      if (!way_valid[w]) free_way = WAY_W'(w);
    end
  end

  assign hit      = |match_vec;
  assign has_free = ~&way_valid;

  // R2: a tag is installed only on a miss, so a set can never hold it twice.
  p_unique_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    probe |-> $onehot0(match_vec));

endmodule

// File: rtl/tagdir_counters.sv
module tagdir_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_access,
  input  logic             inc_miss,
  output logic [CNT_W-1:0] access_count,
  output logic [CNT_W-1:0] miss_count
);

  logic [CNT_W-1:0] acc_q, acc_d, miss_q, miss_d;

  always_comb begin
    acc_d  = acc_q + CNT_W'(1);
    miss_d = miss_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      miss_q <= '0;
    end else begin
      if (inc_access) acc_q  <= acc_d;
      if (inc_miss)   miss_q <= miss_d;
    end
  end

  assign access_count = acc_q;
  assign miss_count   = miss_q;

endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
  import tagdir_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int NUM_SETS    = 32,
  parameter int NUM_WAYS    = 8,
  parameter int CNT_W       = 32,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int TAG_W      = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WAY_W-1:0]  victim_way,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_evict,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  miss_count
);

  // Directory storage: the tags are not reset, since the valid flags gate them.
  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q   [NUM_SETS];
  logic [NUM_WAYS-1:0]            valid_q [NUM_SETS];

  logic             ready_q;
  logic             accept;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] acc_tag;
  logic             hit, has_free;
  logic [WAY_W-1:0] hit_way, free_way, fill_way;
  logic             write_en;
  tagdir_outcome_e  outcome;

  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_hit_q, rsp_hit_d;
  logic             rsp_evict_q, rsp_evict_d;
  logic [WAY_W-1:0] rsp_way_q, rsp_way_d;

  assign req_ready = ready_q;
  assign accept    = req_valid && ready_q;

  tagdir_addr_split #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .SET_W  (SET_W)
  ) u_split (
    .addr    (req_addr),
    .set_idx (set_idx),
    .tag     (acc_tag)
  );

  tagdir_way_search #(
    .NUM_WAYS (NUM_WAYS),
    .TAG_W    (TAG_W)
  ) u_search (
    .clk       (clk),
    .rst_n     (rst_n),
    .probe     (accept),
    .way_tags  (tag_q[set_idx]),
    .way_valid (valid_q[set_idx]),
    .look_tag  (acc_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .has_free  (has_free),
    .free_way  (free_way)
  );

  tagdir_counters #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .inc_access   (accept),
    .inc_miss     (write_en),
    .access_count (access_count),
    .miss_count   (miss_count)
  );

  // Outcome and next state
  always_comb begin
    if (hit)           outcome = OUT_HIT;
    else if (has_free) outcome = OUT_FILL;
    else               outcome = OUT_EVICT;

    fill_way = (outcome == OUT_FILL) ? free_way : victim_way;
    write_en = accept && (outcome != OUT_HIT);

    rsp_valid_d = accept;
    rsp_hit_d   = rsp_hit_q;
    rsp_evict_d = rsp_evict_q;
    rsp_way_d   = rsp_way_q;
    if (accept) begin
      rsp_hit_d   = (outcome == OUT_HIT);
      rsp_evict_d = (outcome == OUT_EVICT);
      rsp_way_d   = (outcome == OUT_HIT) ? hit_way : fill_way;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_evict_q <= 1'b0;
      rsp_way_q   <= '0;
      for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_evict_q <= rsp_evict_d;
      rsp_way_q   <= rsp_way_d;
      if (write_en) valid_q[set_idx][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (write_en) tag_q[set_idx][fill_way] <= acc_tag;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_valid_q && rsp_hit_q;
  assign rsp_miss  = rsp_valid_q && !rsp_hit_q;
  assign rsp_evict = rsp_valid_q && rsp_evict_q;
  assign rsp_way   = rsp_way_q;

  // Checks
  p_rsp_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);
  p_hit_xor_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
  p_hit_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (rsp_hit && rsp_way == $past(hit_way)));
  p_fill_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit && has_free) |=> (!rsp_evict && rsp_way == $past(free_way)));
  p_evict_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit && !has_free) |=> (rsp_evict && rsp_way == $past(victim_way)));
  p_victim_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit && !has_free) |-> (32'(victim_way) < NUM_WAYS));
  p_installed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> valid_q[$past(set_idx)][$past(fill_way)]);
  p_miss_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (miss_count == $past(miss_count) + CNT_W'(1)));
  p_miss_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && !hit) |=> $stable(miss_count));
  p_access_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (access_count == $past(access_count) + CNT_W'(1)));

endmodule

// File: tb/tagdir_top_tb.sv
`timescale 1ns/1ps
module tagdir_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [2:0]  victim_way;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_evict;
  logic [2:0]  rsp_way;
  logic [31:0] access_count, miss_count;

  int n_chk = 0;
  int n_fail = 0;
  int exp_acc = 0;
  int exp_miss = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tagdir_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .victim_way   (victim_way),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_evict    (rsp_evict),
    .rsp_way      (rsp_way),
    .access_count (access_count),
    .miss_count   (miss_count)
  );

  // Address layout: 21-bit tag, 5-bit set index, 6-bit offset.
  function automatic logic [31:0] mk(input logic [20:0] tg, input logic [4:0] st,
                                     input logic [5:0] off);
    return {tg, st, off};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_counts(input string req);
    chk(req, "access_count", 64'(access_count), 64'(exp_acc));
    chk(req, "miss_count", 64'(miss_count), 64'(exp_miss));
  endtask

  // One access: offered at a falling edge, accepted at the next rising edge,
  // and its response sampled at the falling edge that follows.
  task automatic access(input logic [31:0] a, input logic [2:0] vic,
                        input bit e_hit, input int e_way, input bit e_evict,
                        input string req);
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = a;
    victim_way = vic;
    @(negedge clk);
    req_valid = 1'b0;
    exp_acc++;
    if (!e_hit) exp_miss++;
    chk(req, "rsp_valid", 64'(rsp_valid), 64'(1));
    chk(req, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
    chk(req, "rsp_miss", 64'(rsp_miss), 64'(!e_hit));
    chk(req, "rsp_way", 64'(rsp_way), 64'(e_way));
    chk(req, "rsp_evict", 64'(rsp_evict), 64'(e_evict));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    exp_acc = 0;
    exp_miss = 0;
    @(negedge clk);
    chk("R7", "req_ready in reset", 64'(req_ready), 64'(0));
    chk("R7", "rsp_valid in reset", 64'(rsp_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "req_ready after reset", 64'(req_ready), 64'(1));
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_counts("R7");
    chk("R7", "rsp_valid idle", 64'(rsp_valid), 64'(0));
  endtask

  // R3: cold fills go to ways 0..7 in order, with victim_way ignored.
  task automatic t_cold_fill();
    for (int w = 0; w < 8; w++)
      access(mk(21'h100 + 21'(w), 5'd3, 6'd0), 3'd5, 1'b0, w, 1'b0, "R3");
  endtask

  // R2/R5/R1: re-reads hit, at a different offset as well.
  task automatic t_rehit();
    for (int w = 0; w < 8; w++)
      access(mk(21'h100 + 21'(w), 5'd3, 6'h3F), 3'd0, 1'b1, w, 1'b0, "R2_R5");
    access(mk(21'h104, 5'd3, 6'h15), 3'd1, 1'b1, 4, 1'b0, "R1");
  endtask

  // R1: the same tag in another set is a separate entry.
  task automatic t_set_isolation();
    access(mk(21'h100, 5'd4, 6'd0), 3'd7, 1'b0, 0, 1'b0, "R1");
    access(mk(21'h100, 5'd4, 6'd9), 3'd7, 1'b1, 0, 1'b0, "R1");
    access(mk(21'h100, 5'd3, 6'd0), 3'd7, 1'b1, 0, 1'b0, "R1");
  endtask

  // R4/R5: the full set takes victim_way; the overwritten tag is lost.
  task automatic t_evict();
    access(mk(21'h200, 5'd3, 6'd0), 3'd2, 1'b0, 2, 1'b1, "R4");
    access(mk(21'h200, 5'd3, 6'd4), 3'd5, 1'b1, 2, 1'b0, "R5");
    access(mk(21'h102, 5'd3, 6'd0), 3'd6, 1'b0, 6, 1'b1, "R5");
    access(mk(21'h106, 5'd3, 6'd0), 3'd0, 1'b0, 0, 1'b1, "R4");
    access(mk(21'h101, 5'd3, 6'd0), 3'd1, 1'b1, 1, 1'b0, "R4");
  endtask

  // R8: two accesses in consecutive cycles; the second sees the first's fill.
  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = mk(21'h300, 5'd9, 6'd0);
    victim_way = 3'd3;
    @(negedge clk);
    chk("R8", "b2b first valid", 64'(rsp_valid), 64'(1));
    chk("R8", "b2b first miss", 64'(rsp_miss), 64'(1));
    chk("R8", "b2b first way", 64'(rsp_way), 64'(0));
    req_addr = mk(21'h300, 5'd9, 6'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "b2b second valid", 64'(rsp_valid), 64'(1));
    chk("R8", "b2b second hit", 64'(rsp_hit), 64'(1));
    chk("R8", "b2b second way", 64'(rsp_way), 64'(0));
    exp_acc += 2;
    exp_miss += 1;
    @(negedge clk);
    chk("R8", "rsp_valid drops", 64'(rsp_valid), 64'(0));
  endtask

  task automatic t_counters();
    chk_counts("R6");
  endtask

  // R7: reset wipes the directory; a cached block misses into way 0.
  task automatic t_reset_clears();
    do_reset();
    chk_counts("R7");
    access(mk(21'h101, 5'd3, 6'd0), 3'd4, 1'b0, 0, 1'b0, "R7");
    chk_counts("R6");
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    victim_way = '0;
    t_reset_state();
    t_cold_fill();
    t_rehit();
    t_set_isolation();
    t_evict();
    t_back_to_back();
    t_counters();
    t_reset_clears();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule